// File: doc/BRIEF.md
# Two-Level Data Cache with Mixed Write Policies

This block sits between a processor's load/store port and a line-wide main memory port. Every word request is looked up in a small first-level cache. A load that hits there is answered in the cycle it is presented. Everything else goes to a larger, slower second-level cache, which is modelled with a fixed lookup latency. A second-level miss fetches a whole line from memory. If the victim line is dirty, it is first written back in full.

The first level is write-through with no allocation on a store miss. Every store therefore reaches the second level, which is write-back and keeps a dirty bit per line. Four free-running counters expose processor accesses, first-level misses, second-level accesses and second-level misses. The local second-level miss rate is misses over second-level accesses. The global rate is misses over processor accesses.

Top module: `cache_two_level`

## Requirements
- R1: A load whose line is present in the first level completes in the cycle it is presented (cpu_stall low) and returns the word selected by address bits [3:2]. It increments only the CPU access counter.
- R2: A load that misses in the first level but hits in the second completes after exactly L2_LAT+2 stalled cycles, with no memory transfer. A store whose line is present in the second level behaves the same way.
- R3: A second-level miss reads the whole 16-byte line from memory (mem_we low, mem_addr the line base with bits [3:0] zero). It installs the line in both levels for a load and returns the requested word. Such a request stalls for more than L2_LAT+2 cycles.
- R4: A store that hits in the first level updates the word there. It is also written into the second level, so a later second-level read returns the stored value.
- R5: A store that misses in the first level does not allocate a first-level line. A later load of that address is still a first-level miss, and it returns the stored data.
- R6: When a second-level miss evicts a dirty line, the whole victim line is written to memory (mem_we high, at the victim's line address) before the new line is fetched. A clean victim produces no memory write.
- R7: Four counters are kept. cnt_cpu counts requests. cnt_l1_miss counts requests not found in the first level. cnt_l2_acc counts every first-level miss plus every store. cnt_l2_miss counts second-level lookups that miss.
- R8: A memory request holds mem_valid, mem_we, mem_addr and mem_wdata steady until mem_ready is seen.
- R9: Reset clears the four counters and invalidates all lines in both levels. After reset, cpu_stall and mem_valid are low.
- R10: While cpu_req is low, the block counts nothing and makes no memory request, whatever the other CPU inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Request present; held until a cycle with cpu_stall low |
| cpu_we | input | 1 | 1 = store word, 0 = load word |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_stall is low |
| cpu_stall | output | 1 | Request not yet complete |
| mem_valid | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line base address |
| mem_wdata | output | 128 | Line written back |
| mem_rdata | input | 128 | Line returned by memory |
| mem_ready | input | 1 | One-cycle completion pulse for the current transfer |
| cnt_cpu | output | 32 | CPU access count |
| cnt_l1_miss | output | 32 | First-level miss count |
| cnt_l2_acc | output | 32 | Second-level access count |
| cnt_l2_miss | output | 32 | Second-level miss count |

## Verification
The checks inside the design assume two things about the environment. First, the processor keeps cpu_addr, cpu_we and cpu_wdata unchanged while cpu_stall is high, because the block does not latch the request. Second, memory raises mem_ready for exactly one cycle per transfer, and only while mem_valid is high. The stimulus respects both rules. Each request is driven on a falling edge and held until a cycle without stall. The memory model counts a fixed latency from mem_valid and then pulses ready once. The address sequence is chosen so that hits, conflict evictions, dirty and clean victims, and stores without allocation each occur at known points.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_L2WAIT  = 3'd1,
    S_WBACK   = 3'd2,
    S_FETCH   = 3'd3,
    S_RESOLVE = 3'd4,
    S_DONE    = 3'd5
  } ctl_state_e;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 32;
endpackage

// File: rtl/dm_line_store.sv
module dm_line_store #(
  parameter int LINES       = 16,
  parameter int TAG_W       = 24,
  parameter int LINE_W      = 128,
  parameter bit TRACK_DIRTY = 1'b0,
  localparam int IDX_W      = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              lk_dirty,
  output logic [LINE_W-1:0] lk_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_line  = line_q[lk_idx];

  generate
    if (TRACK_DIRTY) begin : g_dirty
      logic [LINES-1:0] dirty_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dirty_q <= '0;
        else if (wr_en) dirty_q[wr_idx] <= wr_dirty;
      end
      assign lk_dirty = dirty_q[lk_idx];

      // R6: only an installed line can carry modified data
      assert_dirty_needs_valid_R6: assert property (
        @(posedge clk) disable iff (!rst_n) lk_dirty |-> lk_valid);
    end else begin : g_clean
      logic unused_dirty;
      assign unused_dirty = wr_dirty;
      assign lk_dirty     = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/miss_counters.sv
module miss_counters #(
  parameter int CNT_W = 32,
  parameter int NUM   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM-1:0]   inc,
  output logic [CNT_W-1:0] cnt [NUM]
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM; gi++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (inc[gi]) cnt_q <= cnt_q + 1'b1;
      end
      assign cnt[gi] = cnt_q;
    end
  endgenerate

  // R7: event order is cpu(0) >= l1 miss(1); l2 access(2) >= l2 miss(3)
  assert_l1m_implies_cpu_R7: assert property (
    @(posedge clk) disable iff (!rst_n) inc[1] |-> inc[0]);
  assert_l2m_implies_l2a_R7: assert property (
    @(posedge clk) disable iff (!rst_n) inc[3] |-> inc[2]);
endmodule

// File: rtl/cache_two_level.sv
module cache_two_level
  import cache_pkg::*;
#(
  parameter int L1_LINES   = 16,
  parameter int L2_LINES   = 64,
  parameter int LINE_WORDS = 4,
  parameter int L2_LAT     = 3,
  parameter int CNT_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [31:0]                  cpu_addr,
  input  logic [31:0]                  cpu_wdata,
  output logic [31:0]                  cpu_rdata,
  output logic                         cpu_stall,
  output logic                         mem_valid,
  output logic                         mem_we,
  output logic [31:0]                  mem_addr,
  output logic [LINE_WORDS*32-1:0]     mem_wdata,
  input  logic [LINE_WORDS*32-1:0]     mem_rdata,
  input  logic                         mem_ready,
  output logic [CNT_W-1:0]             cnt_cpu,
  output logic [CNT_W-1:0]             cnt_l1_miss,
  output logic [CNT_W-1:0]             cnt_l2_acc,
  output logic [CNT_W-1:0]             cnt_l2_miss
);
  localparam int LINE_W = LINE_WORDS * WORD_W;
  localparam int OFF_W  = $clog2(LINE_WORDS * 4);
  localparam int SEL_W  = $clog2(LINE_WORDS);
  localparam int IDX1_W = $clog2(L1_LINES);
  localparam int IDX2_W = $clog2(L2_LINES);
  localparam int TAG1_W = ADDR_W - IDX1_W - OFF_W;
  localparam int TAG2_W = ADDR_W - IDX2_W - OFF_W;
  localparam int LAT_W  = $clog2(L2_LAT + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // address split
  logic [SEL_W-1:0]  sel;
  logic [IDX1_W-1:0] idx1;
  logic [TAG1_W-1:0] tag1;
  logic [IDX2_W-1:0] idx2;
  logic [TAG2_W-1:0] tag2;
  assign sel  = cpu_addr[OFF_W-1:2];
  assign idx1 = cpu_addr[OFF_W +: IDX1_W];
  assign tag1 = cpu_addr[ADDR_W-1 -: TAG1_W];
  assign idx2 = cpu_addr[OFF_W +: IDX2_W];
  assign tag2 = cpu_addr[ADDR_W-1 -: TAG2_W];

  // storage
  logic              l1_vld, l1_dirty_unused, l1_we;
  logic [TAG1_W-1:0] l1_tag;
  logic [LINE_W-1:0] l1_line, l1_wline, l1_merged;
  logic              l2_vld, l2_dirty, l2_we, l2_wdirty;
  logic [TAG2_W-1:0] l2_tag;
  logic [LINE_W-1:0] l2_line, l2_wline, l2_merged;

  dm_line_store #(.LINES(L1_LINES), .TAG_W(TAG1_W), .LINE_W(LINE_W),
                  .TRACK_DIRTY(1'b0)) u_l1 (
    .clk(clk), .rst_n(rst_i),
    .lk_idx(idx1), .lk_valid(l1_vld), .lk_tag(l1_tag),
    .lk_dirty(l1_dirty_unused), .lk_line(l1_line),
    .wr_en(l1_we), .wr_idx(idx1), .wr_tag(tag1),
    .wr_line(l1_wline), .wr_dirty(1'b0));

  dm_line_store #(.LINES(L2_LINES), .TAG_W(TAG2_W), .LINE_W(LINE_W),
                  .TRACK_DIRTY(1'b1)) u_l2 (
    .clk(clk), .rst_n(rst_i),
    .lk_idx(idx2), .lk_valid(l2_vld), .lk_tag(l2_tag),
    .lk_dirty(l2_dirty), .lk_line(l2_line),
    .wr_en(l2_we), .wr_idx(idx2), .wr_tag(tag2),
    .wr_line(l2_wline), .wr_dirty(l2_wdirty));

  logic l1_hit, l2_hit;
  assign l1_hit = l1_vld && (l1_tag == tag1);
  assign l2_hit = l2_vld && (l2_tag == tag2);

  always_comb begin
    l1_merged = l1_line;
    l1_merged[sel*WORD_W +: WORD_W] = cpu_wdata;
    l2_merged = l2_line;
    l2_merged[sel*WORD_W +: WORD_W] = cpu_wdata;
  end

  // control
  ctl_state_e  state_q, state_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [31:0] rdata_q, rdata_d;
  logic        lat_last;
  logic [3:0]  inc;
  logic        unused_l1d;
  assign unused_l1d = l1_dirty_unused;
  assign lat_last   = (lat_q == LAT_W'(L2_LAT - 1));

  always_comb begin
    state_d   = state_q;
    lat_d     = lat_q;
    rdata_d   = rdata_q;
    l1_we     = 1'b0;
    l1_wline  = l2_line;
    l2_we     = 1'b0;
    l2_wline  = mem_rdata;
    l2_wdirty = 1'b0;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    mem_wdata = l2_line;
    inc       = '0;
    unique case (state_q)
      S_IDLE: begin
        if (cpu_req) begin
          inc[0] = 1'b1;
          inc[1] = !l1_hit;
          if (cpu_we || !l1_hit) begin
            state_d = S_L2WAIT;
            lat_d   = '0;
          end
        end
      end
      S_L2WAIT: begin
        if (lat_last) begin
          inc[2] = 1'b1;
          inc[3] = !l2_hit;
          if (l2_hit)                 state_d = S_RESOLVE;
          else if (l2_vld && l2_dirty) state_d = S_WBACK;
          else                         state_d = S_FETCH;
        end else begin
          lat_d = lat_q + 1'b1;
        end
      end
      S_WBACK: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {l2_tag, idx2, {OFF_W{1'b0}}};
        if (mem_ready) state_d = S_FETCH;
      end
      S_FETCH: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          l2_we   = 1'b1;
          state_d = S_RESOLVE;
        end
      end
      S_RESOLVE: begin
        if (cpu_we) begin
          l2_we     = 1'b1;
          l2_wline  = l2_merged;
          l2_wdirty = 1'b1;
          if (l1_hit) begin
            l1_we    = 1'b1;
            l1_wline = l1_merged;
          end
        end else begin
          l1_we   = 1'b1;
          rdata_d = l2_line[sel*WORD_W +: WORD_W];
        end
        state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= S_IDLE;
      lat_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      lat_q   <= lat_d;
      rdata_q <= rdata_d;
    end
  end

  assign cpu_stall = cpu_req &&
                     !((state_q == S_IDLE && !cpu_we && l1_hit) || state_q == S_DONE);
  assign cpu_rdata = (state_q == S_DONE) ? rdata_q : l1_line[sel*WORD_W +: WORD_W];

  logic [CNT_W-1:0] cnt_arr [4];
  miss_counters #(.CNT_W(CNT_W), .NUM(4)) u_cnt (
    .clk(clk), .rst_n(rst_i), .inc(inc), .cnt(cnt_arr));
  assign cnt_cpu     = cnt_arr[0];
  assign cnt_l1_miss = cnt_arr[1];
  assign cnt_l2_acc  = cnt_arr[2];
  assign cnt_l2_miss = cnt_arr[3];

  // R1: a first-level load hit touches only the CPU counter
  assert_l1hit_counts_R1: assert property (
    @(posedge clk) disable iff (!rst_i)
    (state_q == S_IDLE && cpu_req && !cpu_we && l1_hit) |=>
      (cnt_cpu == $past(cnt_cpu) + 1'b1) && (cnt_l1_miss == $past(cnt_l1_miss)) &&
      (cnt_l2_acc == $past(cnt_l2_acc)));

  // R2: a second-level hit never goes to memory
  assert_l2hit_no_mem_R2: assert property (
    @(posedge clk) disable iff (!rst_i)
    (state_q == S_L2WAIT && lat_last && l2_hit) |=> !mem_valid);

  // R3: the fetched line is present in the second level afterwards
  assert_fill_hits_R3: assert property (
    @(posedge clk) disable iff (!rst_i)
    (state_q == S_FETCH && mem_ready) |=> l2_hit);

  // R6: a completed write-back is followed by the line read
  assert_wb_then_fetch_R6: assert property (
    @(posedge clk) disable iff (!rst_i)
    (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we));

  // R8: request fields hold until memory accepts
  assert_mem_hold_R8: assert property (
    @(posedge clk) disable iff (!rst_i)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R10: no request means no counting and no memory traffic
  assert_idle_quiet_R10: assert property (
    @(posedge clk) disable iff (!rst_i)
    (state_q == S_IDLE && !cpu_req) |=> ($stable(cnt_cpu) && !mem_valid));
endmodule

// File: tb/sim_cache_two_level.sv
`timescale 1ns/1ps
module sim_cache_two_level;
  localparam int L2_LAT  = 3;
  localparam int MEM_LAT = 4;
  localparam int NV      = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_stall;
  logic         mem_valid, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;
  logic [31:0]  cnt_cpu, cnt_l1_miss, cnt_l2_acc, cnt_l2_miss;

  always #2.5 clk = ~clk;

  cache_two_level #(.L2_LAT(L2_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .cnt_cpu(cnt_cpu), .cnt_l1_miss(cnt_l1_miss),
    .cnt_l2_acc(cnt_l2_acc), .cnt_l2_miss(cnt_l2_miss));

  // memory model: 16 KB of lines, fixed latency, one-cycle ready pulse
  logic [127:0] mline [1024];
  logic [31:0]  ref_w [4096];
  int           lat_cnt = 0;
  int           mwrites = 0;

  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      lat_cnt   <= 0;
    end else if (mem_valid) begin
      if (lat_cnt == MEM_LAT - 1) begin
        mem_ready <= 1'b1;
        if (mem_we) begin
          mline[mem_addr[13:4]] <= mem_wdata;
          mwrites <= mwrites + 1;
        end else begin
          mem_rdata <= mline[mem_addr[13:4]];
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    stalls = 0;
    #1;
    while (cpu_stall) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
  endtask

  // vector: {we, addr[15:0], wdata[31:0], l1_hit, l2_hit, writeback}
  // A=0x010  B=0x110 (L1 conflict)  C=0x414 / D=0x2010 (L1 and L2 conflict)  E=0x024
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 16'h0010, 32'h0000_0000, 3'b000},  // LD A      cold miss
    {1'b0, 16'h0010, 32'h0000_0000, 3'b100},  // LD A      L1 hit
    {1'b0, 16'h0014, 32'h0000_0000, 3'b100},  // LD A+4    L1 hit same line
    {1'b1, 16'h0018, 32'h1111_1111, 3'b110},  // ST A+8    L1 hit, write through
    {1'b0, 16'h0018, 32'h0000_0000, 3'b100},  // LD A+8    updated in L1
    {1'b0, 16'h0110, 32'h0000_0000, 3'b000},  // LD B      replaces L1 line
    {1'b0, 16'h0018, 32'h0000_0000, 3'b010},  // LD A+8    from L2
    {1'b1, 16'h0414, 32'h2222_2222, 3'b001},  // ST C      dirty A written back
    {1'b0, 16'h0018, 32'h0000_0000, 3'b100},  // LD A+8    still in L1
    {1'b0, 16'h2010, 32'h0000_0000, 3'b001},  // LD D      dirty C written back
    {1'b0, 16'h0414, 32'h0000_0000, 3'b000},  // LD C      clean victim
    {1'b1, 16'h0024, 32'h3333_3333, 3'b000},  // ST E      miss, no L1 alloc
    {1'b0, 16'h0024, 32'h0000_0000, 3'b010}   // LD E      L1 miss, L2 hit
  };

  initial begin
    logic [31:0] rd;
    int st, mw0;
    int e_cpu = 0, e_l1m = 0, e_l2a = 0, e_l2m = 0;
    for (int i = 0; i < 1024; i++)
      for (int w = 0; w < 4; w++) begin
        mline[i][w*32 +: 32] = 32'hC0DE_0000 ^ ((i * 16) + (w * 4));
        ref_w[i*4 + w]       = 32'hC0DE_0000 ^ ((i * 16) + (w * 4));
      end

    repeat (4) @(negedge clk);
    chk(cpu_stall == 1'b0, "R9 stall in reset", {31'b0, cpu_stall}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_stall == 1'b0 && mem_valid == 1'b0, "R9 idle outputs",
        {30'b0, cpu_stall, mem_valid}, 32'h0);
    chk(cnt_cpu == 0 && cnt_l1_miss == 0 && cnt_l2_acc == 0 && cnt_l2_miss == 0,
        "R9 counters zero", cnt_cpu | cnt_l1_miss | cnt_l2_acc | cnt_l2_miss, 32'h0);

    // R10: inputs toggling without a request
    cpu_we = 1'b1; cpu_addr = 32'h0000_0040; cpu_wdata = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 32'h0000_0080;
    repeat (3) @(negedge clk);
    chk(cnt_cpu == 0 && mwrites == 0 && mem_valid == 1'b0, "R10 no request quiet",
        cnt_cpu, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic        we, l1h, l2h, wb;
      logic [15:0] a;
      logic [31:0] wd;
      we = VEC[v][51]; a = VEC[v][50:35]; wd = VEC[v][34:3];
      l1h = VEC[v][2]; l2h = VEC[v][1]; wb = VEC[v][0];
      mw0 = mwrites;
      access(we, {16'h0, a}, wd, rd, st);
      e_cpu++;
      if (!l1h) e_l1m++;
      if (we || !l1h) begin
        e_l2a++;
        if (!l2h) e_l2m++;
      end
      if (we) begin
        ref_w[a[13:2]] = wd;
      end else begin
        chk(rd == ref_w[a[13:2]], l1h ? "R1 load data" : (l2h ? "R2 load data" : "R3 load data"),
            rd, ref_w[a[13:2]]);
      end
      if (!we && l1h)
        chk(st == 0, "R1 hit stall cycles", st, 0);
      else if (l2h)
        chk(st == L2_LAT + 2, we ? "R4 store stall cycles" : "R2 stall cycles", st, L2_LAT + 2);
      else
        chk(st > L2_LAT + 2, we ? "R5 store miss stall" : "R3 miss stall", st, L2_LAT + 3);
      chk((mwrites - mw0) == int'(wb), "R6 write-back count", mwrites - mw0, {31'b0, wb});
    end

    chk(cnt_cpu == e_cpu, "R7 cnt_cpu", cnt_cpu, e_cpu);
    chk(cnt_l1_miss == e_l1m, "R7 cnt_l1_miss", cnt_l1_miss, e_l1m);
    chk(cnt_l2_acc == e_l2a, "R7 cnt_l2_acc", cnt_l2_acc, e_l2a);
    chk(cnt_l2_miss == e_l2m, "R7 cnt_l2_miss", cnt_l2_miss, e_l2m);
    chk(mline[1][95:64] == 32'h1111_1111, "R6 victim A in memory", mline[1][95:64], 32'h1111_1111);
    chk(mline[65][63:32] == 32'h2222_2222, "R6 victim C in memory", mline[65][63:32], 32'h2222_2222);

    // R9: reset invalidates lines and clears counters
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cnt_cpu == 0 && cnt_l2_miss == 0, "R9 counters cleared", cnt_cpu, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 32'h0000_0018, 32'h0, rd, st);
    chk(st > L2_LAT + 2, "R9 lines invalid after reset", st, L2_LAT + 3);
    chk(rd == 32'h1111_1111, "R9 data from memory", rd, 32'h1111_1111);
    chk(cnt_cpu == 1 && cnt_l2_miss == 1, "R9 counts restart", cnt_cpu, 32'h1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule